// File: doc/BRIEF.md
# Two-Wire Slave Transmitter with Status Codes

This block is the read side of a two-wire serial slave that reports its progress through 8-bit status codes. It watches a bus address phase for its own 7-bit address with the read bit set. When it finds it, the block acknowledges, stops at a status code and raises an interrupt flag. It then holds the clock low until software has supplied a byte and cleared the flag. Each byte goes out most significant bit first. The block samples the master's acknowledge, reports the outcome as a new code and stops again.

Software steers the transfer with a few control inputs. The acknowledge-enable level, read when the flag is cleared, decides whether the loaded byte is the last one. The start-request level queues a START for the moment the bus goes free. A set-only stop bit is cleared by hardware on a bus error. A START or STOP that arrives in the middle of a byte aborts the transfer with code 00h and releases both lines. While the flag is clear, the status reads F8h.

Top module: `i2cst_top`

## Requirements
- R1: After reset, status_o is F8h, irq_o, stop_o and start_gen_o are 0, and neither SCL nor SDA is pulled.
- R2: An address byte that equals own_addr_i followed by a read bit of 1, received while ack_en_i is 1, is acknowledged by pulling SDA low during the ninth clock; after that clock falls, irq_o is 1 and status_o is A8h.
- R3: If arb_lost_i is 1 when such a matching read address is decoded, the code is B0h instead of A8h, and the transfer continues as it would after A8h.
- R4: While the block waits for software in a status state (A8h, B0h, B8h, C0h, C8h), it holds SCL low; it releases SCL once irq_clr_i clears the flag.
- R5: Clearing the flag with ack_en_i at 1 sends the data-register byte (written with tx_load_i) MSB first; an acknowledge from the master gives status B8h.
- R6: A data byte that the master does not acknowledge gives status C0h, whether or not it was the last byte.
- R7: A byte released with ack_en_i at 0 is the last one: if the master acknowledges it, the status is C8h, and every later bit the master clocks reads as 1 because SDA is no longer pulled.
- R8: In not-addressed mode, an address byte that differs from own_addr_i, has a read bit of 0, or arrives while ack_en_i is 0 gets no acknowledge and sets no flag.
- R9: The general-call byte 00h is acknowledged only while both gc_en_i and ack_en_i are 1. It sets no flag, because this block has no receive path.
- R10: If start_req_i is 1 when the flag is cleared after C0h or C8h, start_gen_o pulses for one cycle once the bus is free, meaning after a STOP has been detected, and not before.
- R11: A START or STOP detected in the middle of a byte sets irq_o with status 00h, releases SDA and SCL, and clears stop_o, with no STOP put on the bus.
- R12: Whenever irq_o is 0, status_o reads F8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Clock line level as seen on the bus |
| sda_i | input | 1 | Data line level as seen on the bus |
| scl_pull_o | output | 1 | 1 pulls the clock line low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| own_addr_i | input | 7 | Own slave address |
| gc_en_i | input | 1 | Enables recognition of the general-call address |
| ack_en_i | input | 1 | Acknowledge enable; 0 marks the next byte as the last one |
| arb_lost_i | input | 1 | Arbitration-lost indication from the master side |
| tx_load_i | input | 1 | Strobe that writes tx_byte_i into the data register |
| tx_byte_i | input | 8 | Byte to transmit |
| irq_clr_i | input | 1 | Strobe that clears the interrupt flag and resumes the transfer |
| start_req_i | input | 1 | Request for a START once the bus is free |
| stop_set_i | input | 1 | Strobe that sets the stop bit |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |
| stop_o | output | 1 | Stop bit |
| start_gen_o | output | 1 | One-cycle pulse issuing the queued START |

## Verification
Some rules are checked on every cycle by assertions in the design. A new flag always carries one of the defined codes. The clock is only stretched while the flag is up. SDA is released while the master's acknowledge is sampled. A bus error leaves both lines free and the stop bit clear. The START pulse lasts exactly one cycle. Other behaviour depends on a whole bus transaction and shows only in the bench's scenarios, which drive a master model through the open-drain lines. These cover the order of the codes, MSB-first byte contents, the all-ones read after the last byte, address rejection and the general-call gating, and the timing of the queued START against the STOP.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

    typedef enum logic [7:0] {
        CODE_SLA_RD     = 8'hA8,
        CODE_ARB_SLA_RD = 8'hB0,
        CODE_BYTE_ACK   = 8'hB8,
        CODE_BYTE_NACK  = 8'hC0,
        CODE_LAST_ACK   = 8'hC8,
        CODE_NONE       = 8'hF8,
        CODE_BUS_ERR    = 8'h00
    } stat_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_DECIDE,
        S_ACKDRV,
        S_WAIT,
        S_TX,
        S_MACK,
        S_ERR
    } fsm_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic stat_e byte_outcome(input logic last, input logic acked);
        if (!acked)
            return CODE_BYTE_NACK;
        else if (last)
            return CODE_LAST_ACK;
        else
            return CODE_BYTE_ACK;
    endfunction

endpackage

// File: rtl/i2cst_bus_sync.sv
module i2cst_bus_sync
    import i2cst_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] cur;
    logic [NLINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) begin
                ff      <= '1;
                prev[i] <= 1'b1;
            end else begin
                ff      <= {ff[STAGES-2:0], raw[i]};
                prev[i] <= ff[STAGES-1];
            end
        end
        assign cur[i] = ff[STAGES-1];
    end

    // index 1 = clock line, index 0 = data line
    always_comb begin
        ev.sda      = cur[0];
        ev.scl_rise = cur[1] & ~prev[1];
        ev.scl_fall = ~cur[1] & prev[1];
        ev.start    = cur[1] & prev[1] & prev[0] & ~cur[0];
        ev.stop     = cur[1] & prev[1] & ~prev[0] & cur[0];
    end

endmodule

// File: rtl/i2cst_addr_match.sv
module i2cst_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    output logic              own_rd_hit,
    output logic              gc_hit
);
    logic [ADDR_W:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            sr_q <= '0;
        else if (shift)
            sr_q <= {sr_q[ADDR_W-1:0], bit_in};
    end

    assign own_rd_hit = ack_en && (sr_q[ADDR_W:1] == own_addr) && sr_q[0];
    assign gc_hit     = ack_en && gc_en && (sr_q == '0);

endmodule

// File: rtl/i2cst_tx_shift.sv
module i2cst_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              shift,
    output logic              msb
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '1;
        else if (load)
            sh_q <= din;
        else if (shift)
            sh_q <= {sh_q[DATA_W-2:0], 1'b1};
    end

    assign msb = sh_q[DATA_W-1];

endmodule

// File: rtl/i2cst_top.sv
module i2cst_top
    import i2cst_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    input  logic              ack_en_i,
    input  logic              arb_lost_i,
    input  logic              tx_load_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              irq_clr_i,
    input  logic              start_req_i,
    input  logic              stop_set_i,
    output logic              irq_o,
    output logic [7:0]        status_o,
    output logic              stop_o,
    output logic              start_gen_o
);
    localparam int MAXW  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_W = $clog2(MAXW + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    bus_ev_t ev;
    fsm_e    st_q;
    stat_e   code_q;

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    logic irq_q, stop_q, busy_q, pend_q, start_q;
    logic last_q, acked_q, end_q, gc_q, arb_q, ack_drv_q;
    logic own_hit, gc_hit, tx_msb;
    logic mid_xfer, bus_err, sw_go;

    i2cst_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cst_addr_match #(.ADDR_W(ADDR_W)) i_match (
        .clk        (clk),
        .rst        (rst),
        .clear      (ev.start),
        .shift      ((st_q == S_ADDR) && ev.scl_rise),
        .bit_in     (ev.sda),
        .own_addr   (own_addr_i),
        .gc_en      (gc_en_i),
        .ack_en     (ack_en_i),
        .own_rd_hit (own_hit),
        .gc_hit     (gc_hit)
    );

    assign sw_go = (st_q == S_WAIT) && irq_clr_i && !end_q;

    i2cst_tx_shift #(.DATA_W(DATA_W)) i_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (sw_go),
        .din   (data_q),
        .shift ((st_q == S_TX) && ev.scl_fall && (cnt_q != DATA_LAST)),
        .msb   (tx_msb)
    );

    assign mid_xfer = ((st_q == S_ADDR) && (cnt_q != '0)) || (st_q == S_DECIDE) ||
                      (st_q == S_ACKDRV) || (st_q == S_TX) || (st_q == S_MACK);
    assign bus_err  = mid_xfer && (ev.start || ev.stop);

    // data register
    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (tx_load_i)
            data_q <= tx_byte_i;
    end

    // stop bit: set by software, cleared by a bus error
    always_ff @(posedge clk) begin
        if (rst || bus_err)
            stop_q <= 1'b0;
        else if (stop_set_i)
            stop_q <= 1'b1;
    end

    // bus busy tracking and queued START
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (ev.start)
                busy_q <= 1'b1;
            else if (ev.stop)
                busy_q <= 1'b0;
            if ((st_q == S_WAIT) && irq_clr_i && end_q && start_req_i)
                pend_q <= 1'b1;
            else if (pend_q && !busy_q) begin
                pend_q  <= 1'b0;
                start_q <= 1'b1;
            end
        end
    end

    // main sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            code_q    <= CODE_NONE;
            irq_q     <= 1'b0;
            cnt_q     <= '0;
            last_q    <= 1'b0;
            acked_q   <= 1'b0;
            end_q     <= 1'b0;
            gc_q      <= 1'b0;
            arb_q     <= 1'b0;
            ack_drv_q <= 1'b0;
        end else if (bus_err) begin
            st_q      <= S_ERR;
            code_q    <= CODE_BUS_ERR;
            irq_q     <= 1'b1;
            ack_drv_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            unique case (st_q)
                S_IDLE, S_ADDR: begin
                    if (ev.start) begin
                        st_q  <= S_ADDR;
                        cnt_q <= '0;
                    end else if (st_q == S_ADDR && ev.stop) begin
                        st_q <= S_IDLE;
                    end else if (st_q == S_ADDR && ev.scl_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == ADDR_LAST)
                            st_q <= S_DECIDE;
                    end
                end
                S_DECIDE: begin
                    if (own_hit || gc_hit) begin
                        st_q  <= S_ACKDRV;
                        gc_q  <= !own_hit;
                        arb_q <= arb_lost_i;
                    end else begin
                        st_q <= S_IDLE;
                    end
                end
                S_ACKDRV: begin
                    if (ev.scl_fall) begin
                        if (!ack_drv_q) begin
                            ack_drv_q <= 1'b1;
                        end else begin
                            ack_drv_q <= 1'b0;
                            if (gc_q) begin
                                st_q <= S_IDLE;
                            end else begin
                                st_q   <= S_WAIT;
                                irq_q  <= 1'b1;
                                end_q  <= 1'b0;
                                code_q <= arb_q ? CODE_ARB_SLA_RD : CODE_SLA_RD;
                            end
                        end
                    end
                end
                S_WAIT: begin
                    if (irq_clr_i) begin
                        irq_q <= 1'b0;
                        if (end_q) begin
                            st_q <= S_IDLE;
                        end else begin
                            st_q   <= S_TX;
                            cnt_q  <= '0;
                            last_q <= !ack_en_i;
                        end
                    end
                end
                S_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt_q == DATA_LAST) begin
                            st_q  <= S_MACK;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                S_MACK: begin
                    if (ev.scl_rise) begin
                        acked_q <= !ev.sda;
                    end else if (ev.scl_fall) begin
                        st_q   <= S_WAIT;
                        irq_q  <= 1'b1;
                        code_q <= byte_outcome(last_q, acked_q);
                        end_q  <= !acked_q || last_q;
                    end
                end
                S_ERR: begin
                    if (irq_clr_i) begin
                        irq_q <= 1'b0;
                        st_q  <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign scl_pull_o  = (st_q == S_WAIT);
    assign sda_pull_o  = ack_drv_q || ((st_q == S_TX) && !tx_msb);
    assign irq_o       = irq_q;
    assign status_o    = irq_q ? code_q : CODE_NONE;
    assign stop_o      = stop_q;
    assign start_gen_o = start_q;

    // R2 R3 R5 R6 R7 R11
    irq_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> (code_q == CODE_SLA_RD || code_q == CODE_ARB_SLA_RD ||
                          code_q == CODE_BYTE_ACK || code_q == CODE_BYTE_NACK ||
                          code_q == CODE_LAST_ACK || code_q == CODE_BUS_ERR));

    // R4
    stretch_needs_irq_chk: assert property (@(posedge clk) disable iff (rst)
        scl_pull_o |-> irq_q);

    // R6
    mack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_MACK) |-> !sda_pull_o);

    // R11
    bus_err_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_q) && code_q == CODE_BUS_ERR) |-> (!scl_pull_o && !sda_pull_o && !stop_q));

    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    // R10
    start_clears_pend_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |-> !pend_q);

endmodule

// File: tb/test_i2cst_top.sv
module test_i2cst_top;
    localparam int CLK_PERIOD = 10;
    localparam int H = 12;

    typedef struct {
        string      req;
        logic [7:0] code;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_pull, sda_pull;
    logic [6:0] own_addr = 7'h5A;
    logic gc_en = 1'b0, ack_en = 1'b1, arb_lost = 1'b0;
    logic tx_load = 1'b0, irq_clr = 1'b0, start_req = 1'b0, stop_set = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic irq, stop_bit, start_gen;
    logic [7:0] status;
    logic scl_line, sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    int start_cnt = 0;
    logic irq_d = 1'b0;
    exp_t exp_q[$];

    assign scl_line = scl_m & ~scl_pull;
    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cst_top i_i2cst_top (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_line),
        .sda_i       (sda_line),
        .scl_pull_o  (scl_pull),
        .sda_pull_o  (sda_pull),
        .own_addr_i  (own_addr),
        .gc_en_i     (gc_en),
        .ack_en_i    (ack_en),
        .arb_lost_i  (arb_lost),
        .tx_load_i   (tx_load),
        .tx_byte_i   (tx_byte),
        .irq_clr_i   (irq_clr),
        .start_req_i (start_req),
        .stop_set_i  (stop_set),
        .irq_o       (irq),
        .status_o    (status),
        .stop_o      (stop_bit),
        .start_gen_o (start_gen)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_code(input string req, input logic [7:0] code);
        exp_t e;
        e.req  = req;
        e.code = code;
        exp_q.push_back(e);
    endtask

    // monitor: each rising interrupt flag pops one expected status code
    always @(negedge clk) begin
        irq_d <= irq;
        if (!rst && start_gen) start_cnt++;
        if (!rst && irq && !irq_d) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected flag: actual %0h expected none", status);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (status !== e.code) begin
                    n_bad++;
                    $display("FAIL %s: actual %0h expected %0h", e.req, status, e.code);
                end
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b; wt(H);
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
        wt(H);
        r = sda_line;
        scl_m = 1'b0; wt(H);
    endtask

    task automatic m_addr(input logic [6:0] a, input logic rw, output logic acked);
        logic r;
        logic [7:0] byt;
        byt = {a, rw};
        for (int i = 7; i >= 0; i--) m_bit(byt[i], r);
        m_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic m_rd(input logic mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(!mack, r);
    endtask

    task automatic sw_load(input logic [7:0] b);
        tx_byte = b; tx_load = 1'b1; wt(1); tx_load = 1'b0;
    endtask

    task automatic sw_clear(input logic aa, input logic sreq);
        ack_en = aa; start_req = sreq;
        irq_clr = 1'b1; wt(1); irq_clr = 1'b0;
        start_req = 1'b0; wt(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] d;
        wt(5);
        rst = 1'b0;
        wt(2);
        // R1
        chk("R1 status", status, 8'hF8);
        chk("R1 irq", irq, 0);
        chk("R1 pulls", {scl_pull, sda_pull}, 0);
        chk("R1 stop/start", {stop_bit, start_gen}, 0);

        // R2 R4 R5 R7 R10: read of two bytes, last one acknowledged
        expect_code("R2 own read", 8'hA8);
        m_start();
        m_addr(7'h5A, 1'b1, ak);
        chk("R2 address ack", ak, 1);
        chk("R2 irq", irq, 1);
        scl_m = 1'b1; wt(H);
        chk("R4 clock held low", scl_line, 0);
        scl_m = 1'b0; wt(2);
        sw_load(8'hC3);
        sw_clear(1'b1, 1'b0);
        chk("R4 clock released", scl_pull, 0);
        expect_code("R5 byte acked", 8'hB8);
        m_rd(1'b1, d);
        chk("R5 first byte", d, 8'hC3);
        sw_load(8'h5E);
        sw_clear(1'b0, 1'b0);
        expect_code("R7 last byte acked", 8'hC8);
        m_rd(1'b1, d);
        chk("R7 last byte", d, 8'h5E);
        sw_clear(1'b1, 1'b1);
        m_rd(1'b0, d);
        chk("R7 ones after last", d, 8'hFF);
        chk("R12 idle status", status, 8'hF8);
        chk("R10 no start while busy", start_cnt, 0);
        m_stop();
        wt(8);
        chk("R10 start after stop", start_cnt, 1);

        // R6: master NACK
        expect_code("R2 own read", 8'hA8);
        m_start();
        m_addr(7'h5A, 1'b1, ak);
        sw_load(8'h81);
        sw_clear(1'b1, 1'b0);
        expect_code("R6 byte nacked", 8'hC0);
        m_rd(1'b0, d);
        chk("R6 byte", d, 8'h81);
        sw_clear(1'b1, 1'b0);
        m_stop();
        chk("R12 status after clear", status, 8'hF8);
        chk("R10 no start without request", start_cnt, 1);

        // R3: arbitration lost with own read address
        arb_lost = 1'b1;
        expect_code("R3 arb lost read", 8'hB0);
        m_start();
        m_addr(7'h5A, 1'b1, ak);
        chk("R3 address ack", ak, 1);
        arb_lost = 1'b0;
        sw_load(8'h3C);
        sw_clear(1'b1, 1'b0);
        expect_code("R3 byte acked", 8'hB8);
        m_rd(1'b1, d);
        chk("R3 byte", d, 8'h3C);
        sw_load(8'h00);
        sw_clear(1'b0, 1'b0);
        expect_code("R6 last nacked", 8'hC0);
        m_rd(1'b0, d);
        chk("R6 zero byte", d, 8'h00);
        sw_clear(1'b1, 1'b0);
        m_stop();

        // R8: rejected addresses
        m_start(); m_addr(7'h5A, 1'b0, ak); m_stop();
        chk("R8 write bit no ack", ak, 0);
        m_start(); m_addr(7'h5B, 1'b1, ak); m_stop();
        chk("R8 other address no ack", ak, 0);
        ack_en = 1'b0;
        m_start(); m_addr(7'h5A, 1'b1, ak); m_stop();
        chk("R8 ack disabled no ack", ak, 0);
        chk("R8 no flag", irq, 0);

        // R9: general call gating
        ack_en = 1'b1; gc_en = 1'b0;
        m_start(); m_addr(7'h00, 1'b0, ak); m_stop();
        chk("R9 gc disabled", ak, 0);
        gc_en = 1'b1;
        m_start(); m_addr(7'h00, 1'b0, ak); m_stop();
        chk("R9 gc enabled", ak, 1);
        chk("R9 gc no flag", irq, 0);
        ack_en = 1'b0;
        m_start(); m_addr(7'h00, 1'b0, ak); m_stop();
        chk("R9 gc with ack off", ak, 0);
        ack_en = 1'b1; gc_en = 1'b0;

        // R11: STOP in the middle of a byte
        stop_set = 1'b1; wt(1); stop_set = 1'b0; wt(1);
        chk("R11 stop bit set", stop_bit, 1);
        expect_code("R2 own read", 8'hA8);
        m_start();
        m_addr(7'h5A, 1'b1, ak);
        sw_load(8'hFF);
        sw_clear(1'b1, 1'b0);
        expect_code("R11 bus error", 8'h00);
        m_bit(1'b1, ak);
        m_bit(1'b1, ak);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
        chk("R11 irq", irq, 1);
        chk("R11 stop cleared", stop_bit, 0);
        chk("R11 lines released", {scl_pull, sda_pull}, 0);
        sw_clear(1'b1, 1'b0);
        chk("R12 after error", status, 8'hF8);
        chk("scoreboard drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule